// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against runaway software and can also act as a periodic tick source. A 16-bit up-counter, which software cannot read or write, advances on one of two qualifying clock enables: a fast one or a slow auxiliary one. The counter "expires" when a selected bit of it rises. There are four such tap positions. Combined with the two enables, this gives eight distinct intervals.

Software reaches the block only through a 16-bit control word. A write is accepted only when its upper byte carries the write key 5Ah. Any other upper byte is treated as tampering and resets the system at once. Reads return a fixed 69h in the upper byte.

In watchdog mode an expiry pulses the system reset output and marks the cause in a status flag. In interval mode an expiry raises that flag as an interrupt request and the period starts again. Acknowledging the interrupt clears the flag.

Top module: `wdt_keyed_timer`

## Requirements
- R1: A write whose upper byte is 5Ah stores the lower byte, and reads return it in rdData[7:0]. The lower byte is laid out as follows: bits 1:0 tap select, bit 2 clock source, bit 3 counter clear, bit 4 mode, bit 5 and bit 6 two stored pin-control bits, bit 7 hold. Bit 3 always reads back as 0.
- R2: A write with any other upper byte is a key violation. At the next clock edge it produces a one-cycle sysReset pulse, sets wdtFlag, returns the control byte to 00h and clears the counter.
- R3: rdData[15:8] always reads 69h.
- R4: The tap select picks the expiry count. 00 gives 2^15 counted ticks, 01 gives 2^13, 10 gives 2^9 and 11 gives 2^6. Expiry happens on the tick that makes the selected counter bit rise, and the counter then restarts at zero.
- R5: With bit 2 at 0 only fastTick advances the counter. With bit 2 at 1 only slowTick advances it.
- R6: An accepted write with bit 3 set restarts the counter at zero at that edge. This takes priority over a tick in the same cycle.
- R7: In watchdog mode (bit 4 = 0) an expiry gives a one-cycle sysReset pulse at the next edge. It also sets wdtFlag and returns the control byte to 00h.
- R8: In interval mode (bit 4 = 1) an expiry sets wdtFlag without a reset, and the period repeats.
- R9: With bit 7 set the counter keeps its value. After bit 7 is cleared, counting continues from that value.
- R10: After rstN the read value is 6900h, and wdtFlag and sysReset are low.
- R11: In interval mode, irqAck clears wdtFlag, and irqReq equals wdtFlag AND irqEnable. In watchdog mode irqAck leaves wdtFlag unchanged and irqReq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| fastTick | input | 1 | Fast clock enable |
| slowTick | input | 1 | Slow auxiliary clock enable |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 16 | Control write data: key in the upper byte, settings in the lower byte |
| rdData | output | 16 | Control read data |
| irqAck | input | 1 | Interrupt acknowledge |
| irqEnable | input | 1 | Interrupt enable from the system's enable register |
| irqReq | output | 1 | Interval interrupt request |
| wdtFlag | output | 1 | Expiry / reset-cause flag |
| sysReset | output | 1 | One-cycle system reset pulse |

## Verification
Directed runs use the shortest taps with a tick on every cycle, so that the expiry edge can be counted exactly. Hold is applied part way through a period; this separates a counter that resumes its value from one that restarts. The slow source is tested with a sparse slowTick while fastTick stays high, which shows that the unselected enable is ignored. One full 2^15 watchdog timeout and a wrong-key write are included to separate the two reset causes from interval behaviour. A seeded random phase then mixes writes, ticks, holds and acknowledges against a cycle model derived from the requirements. This exposes ordering effects such as a clear colliding with an expiry, or an acknowledge arriving in the same cycle as a new expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] KEY_WRITE = 8'h5A;
  localparam logic [7:0] KEY_READ  = 8'h69;

  // Control byte, msb first: bit7 hold ... bits1:0 tap select
  typedef struct packed {
    logic       hold;
    logic       pinEdge;
    logic       pinFunc;
    logic       modeIntv;
    logic       clrReq;
    logic       srcSlow;
    logic [1:0] tapSel;
  } ctlByte_t;

  // Strobes from control to the counter path
  typedef struct packed {
    logic       cntClr;
    logic       hold;
    logic       srcSlow;
    logic [1:0] tapSel;
  } dpStrobe_t;

endpackage

// File: rtl/wdt_count_path.sv
module wdt_count_path
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP_A = 15,
  parameter int TAP_B = 13,
  parameter int TAP_C = 9,
  parameter int TAP_D = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fastTick,
  input  logic      slowTick,
  input  dpStrobe_t strobe,
  output logic      expire
);

  localparam int NUM_TAPS = 4;
  localparam int TAP_POS [NUM_TAPS] = '{TAP_A, TAP_B, TAP_C, TAP_D};

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    nxt;
  logic [NUM_TAPS-1:0] tapRise;
  logic                advance;

  assign advance = !strobe.hold && (strobe.srcSlow ? slowTick : fastTick);
  assign nxt     = cnt + 1'b1;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tapRise[g] = nxt[TAP_POS[g]] & ~cnt[TAP_POS[g]];
  end

  assign expire = advance && tapRise[strobe.tapSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (strobe.cntClr || expire) cnt <= '0;
    else if (advance)               cnt <= nxt;
  end

  // R6: a clear strobe leaves the counter at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> cnt == '0);

  // R9: hold freezes the count
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hold && !strobe.cntClr) |=> $stable(cnt));

  // R4: the period restarts from zero after expiry
  a_r4_restart: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> cnt == '0);

endmodule

// File: rtl/wdt_ctrl_unit.sv
module wdt_ctrl_unit
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        irqAck,
  input  logic        irqEnable,
  input  logic        expire,
  output dpStrobe_t   strobe,
  output logic [15:0] rdData,
  output logic        sysReset,
  output logic        wdtFlag,
  output logic        irqReq
);

  ctlByte_t ctl;
  ctlByte_t wrByte;
  logic     keyOk;
  logic     keyBad;
  logic     wdExpire;
  logic     resetEvent;

  assign keyOk      = wrData[15:8] == KEY_WRITE;
  assign keyBad     = wrEn && !keyOk;
  assign wdExpire   = expire && !ctl.modeIntv;
  assign resetEvent = keyBad || wdExpire;

  always_comb begin
    wrByte        = ctlByte_t'(wrData[7:0]);
    wrByte.clrReq = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl      <= '0;
      sysReset <= 1'b0;
      wdtFlag  <= 1'b0;
    end else begin
      sysReset <= resetEvent;
      if (resetEvent)          ctl <= '0;
      else if (wrEn && keyOk)  ctl <= wrByte;
      if (resetEvent || (expire && ctl.modeIntv)) wdtFlag <= 1'b1;
      else if (irqAck && ctl.modeIntv)            wdtFlag <= 1'b0;
    end
  end

  always_comb begin
    strobe.cntClr  = keyBad || (wrEn && keyOk && wrData[3]);
    strobe.hold    = ctl.hold;
    strobe.srcSlow = ctl.srcSlow;
    strobe.tapSel  = ctl.tapSel;
  end

  assign rdData = {KEY_READ, ctl};
  assign irqReq = wdtFlag && irqEnable && ctl.modeIntv;

  // R2: wrong key resets at the next edge and marks the cause
  a_r2_badkey: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] != 8'h5A) |=> (sysReset && wdtFlag && rdData[7:0] == 8'h00));

  // R7: watchdog timeout pulses reset
  a_r7_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctl.modeIntv) |=> (sysReset && wdtFlag));

  // R8: interval expiry never resets unless the key is also broken
  a_r8_no_reset: assert property (@(posedge clk) disable iff (!rstN)
    (expire && ctl.modeIntv && !(wrEn && wrData[15:8] != 8'h5A)) |=> (!sysReset && wdtFlag));

  // R11: acknowledge clears the flag in interval mode
  a_r11_ack: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && ctl.modeIntv && !expire && !wrEn) |=> !wdtFlag);

endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP_A = 15,
  parameter int TAP_B = 13,
  parameter int TAP_C = 9,
  parameter int TAP_D = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fastTick,
  input  logic        slowTick,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        irqAck,
  input  logic        irqEnable,
  output logic        irqReq,
  output logic        wdtFlag,
  output logic        sysReset
);

  dpStrobe_t strobe;
  logic      expire;

  wdt_ctrl_unit u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .irqAck    (irqAck),
    .irqEnable (irqEnable),
    .expire    (expire),
    .strobe    (strobe),
    .rdData    (rdData),
    .sysReset  (sysReset),
    .wdtFlag   (wdtFlag),
    .irqReq    (irqReq)
  );

  wdt_count_path #(
    .CNT_W (CNT_W),
    .TAP_A (TAP_A),
    .TAP_B (TAP_B),
    .TAP_C (TAP_C),
    .TAP_D (TAP_D)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .fastTick (fastTick),
    .slowTick (slowTick),
    .strobe   (strobe),
    .expire   (expire)
  );

endmodule

// File: tb/wdt_keyed_timer_tb.sv
module wdt_keyed_timer_tb;

  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fastTick = 1'b0, slowTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqAck = 1'b0, irqEnable = 1'b0;
  logic        irqReq, wdtFlag, sysReset;

  int testCnt = 0, failCnt = 0, cyc = 0;
  logic modelOn = 1'b0;
  logic finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdt_keyed_timer u_dut (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .slowTick(slowTick),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqAck(irqAck),
    .irqEnable(irqEnable), .irqReq(irqReq), .wdtFlag(wdtFlag), .sysReset(sysReset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Expected tap bit per tap select code (R4)
  function automatic int tapOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return 15;
      2'b01:   return 13;
      2'b10:   return 9;
      default: return 6;
    endcase
  endfunction

  // Cycle model built from the requirements
  logic [15:0] mCnt;
  logic [7:0]  mCtl;
  logic        mFlag, mRst;

  always @(posedge clk or negedge rstN) begin
    logic        adv, expNow, bad, ok;
    logic [16:0] nx;
    int          k;
    if (!rstN) begin
      mCnt <= '0; mCtl <= '0; mFlag <= 1'b0; mRst <= 1'b0;
    end else begin
      k      = tapOf(mCtl[1:0]);
      adv    = !mCtl[7] && (mCtl[2] ? slowTick : fastTick);
      nx     = {1'b0, mCnt} + 17'd1;
      expNow = adv && nx[k] && !mCnt[k];
      bad    = wrEn && wrData[15:8] != 8'h5A;
      ok     = wrEn && !bad;
      if (bad || (expNow && !mCtl[4])) begin
        mCtl <= 8'h00; mCnt <= '0; mFlag <= 1'b1; mRst <= 1'b1;
      end else begin
        mRst <= 1'b0;
        if (ok) mCtl <= wrData[7:0] & 8'hF7;
        if ((ok && wrData[3]) || expNow) mCnt <= '0;
        else if (adv)                    mCnt <= nx[15:0];
        if (expNow)                      mFlag <= 1'b1;
        else if (irqAck && mCtl[4])      mFlag <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (modelOn && rstN) begin
      chk("R1 R3 rdData", 32'(rdData), 32'({8'h69, mCtl}));
      chk("R7 sysReset", 32'(sysReset), 32'(mRst));
      chk("R8 wdtFlag", 32'(wdtFlag), 32'(mFlag));
      chk("R11 irqReq", 32'(irqReq), 32'(mFlag & irqEnable & mCtl[4]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !finished) begin
      failCnt++; testCnt++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtl(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; fastTick = 0; slowTick = 0; wrEn = 0; irqAck = 0; irqEnable = 0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelOn = 1'b1;
    doReset();

    // R10 reset state
    chk("R10 rdData", 32'(rdData), 32'h6900);
    chk("R10 wdtFlag", 32'(wdtFlag), 0);
    chk("R10 sysReset", 32'(sysReset), 0);

    // R1 accepted write, clear bit reads 0; R4/R8 interval tap 2^6
    fastTick = 1'b1;
    wrCtl(16'h5A7B);
    chk("R1 stored byte", 32'(rdData), 32'h6973);
    tick(63);
    chk("R4 no early expiry", 32'(wdtFlag), 0);
    tick(1);
    chk("R4 expiry at 64", 32'(wdtFlag), 1);
    chk("R8 no reset", 32'(sysReset), 0);
    irqEnable = 1'b1;
    tick(1);
    chk("R11 irqReq set", 32'(irqReq), 1);
    irqEnable = 1'b0;
    tick(1);
    chk("R11 irqReq masked", 32'(irqReq), 0);
    chk("R11 flag kept", 32'(wdtFlag), 1);
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    chk("R11 ack clears", 32'(wdtFlag), 0);
    tick(60);
    chk("R8 second period pending", 32'(wdtFlag), 0);
    tick(1);
    chk("R8 period repeats", 32'(wdtFlag), 1);

    // R9 hold mid-period
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    wrCtl(16'h5A1B);
    tick(29);
    wrCtl(16'h5A93);
    tick(100);
    chk("R9 held no expiry", 32'(wdtFlag), 0);
    wrCtl(16'h5A13);
    tick(33);
    chk("R9 resume not early", 32'(wdtFlag), 0);
    tick(1);
    chk("R9 resumes from kept value", 32'(wdtFlag), 1);

    // R5 slow source, fast held high
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    wrCtl(16'h5A1F);
    for (int i = 0; i < 64; i++) begin
      slowTick = 1'b1; tick(1); slowTick = 1'b0;
      if (i == 62) chk("R5 slow not early", 32'(wdtFlag), 0);
      if (i == 63) chk("R5 slow expiry", 32'(wdtFlag), 1);
      tick(3);
    end

    // R6 clear restarts counter
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    wrCtl(16'h5A1B);
    tick(50);
    wrCtl(16'h5A1B);
    tick(63);
    chk("R6 cleared, no expiry", 32'(wdtFlag), 0);
    tick(1);
    chk("R6 expiry after clear", 32'(wdtFlag), 1);

    // R2 key violation
    wrCtl(16'h5A12);
    chk("R1 mode byte", 32'(rdData), 32'h6912);
    wrCtl(16'hA512);
    chk("R2 reset pulse", 32'(sysReset), 1);
    chk("R2 flag", 32'(wdtFlag), 1);
    chk("R2 defaults", 32'(rdData), 32'h6900);
    tick(1);
    chk("R2 pulse one cycle", 32'(sysReset), 0);

    // R7 default watchdog timeout at 2^15
    doReset();
    fastTick = 1'b1;
    wrCtl(16'h5A08);
    tick(32767);
    chk("R7 no early reset", 32'(sysReset), 0);
    tick(1);
    chk("R7 timeout reset", 32'(sysReset), 1);
    chk("R7 flag", 32'(wdtFlag), 1);
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    chk("R11 ack ignored in watchdog", 32'(wdtFlag), 1);
    chk("R7 pulse ended", 32'(sysReset), 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] lo;
      fastTick  = ($urandom % 4) != 0;
      slowTick  = ($urandom % 4) == 0;
      irqAck    = ($urandom % 8) == 0;
      irqEnable = $urandom % 2;
      wrEn      = ($urandom % 24) == 0;
      lo        = 8'($urandom);
      lo[1]     = 1'b1;
      lo[7]     = ($urandom % 8) == 0;
      wrData    = {(($urandom % 16) == 0) ? 8'($urandom) : 8'h5A, lo};
      tick(1);
    end
    wrEn = 1'b0; irqAck = 1'b0;
    tick(2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule